// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns a serial receive line back into characters. The configuration inputs set the character width, parity, stop bits, clocking mode and clock polarity. They match the settings of the companion transmitter and stay constant while a frame is in flight. A frame is a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high, and one frame may follow the previous one with no gap.

Asynchronous mode needs no clock from the far end. A free-running strobe `os_tick_i` pulses sixteen times per bit period. A falling edge on the line starts a timing phase, and each bit is sampled at the middle of its period. Synchronous mode has a separate bit clock. As a slave, the block takes that clock from `xck_i`. As a master, it drives the clock on `xck_o`. The polarity input selects the clock edge on which the line is sampled, and the transmitter changes data on the other edge. Each finished character comes out with a one-cycle valid strobe and two error flags.

Top module: `usart_frame_rx`

## Requirements
- R1: In asynchronous mode a falling edge on the line starts a candidate frame. On the 8th `os_tick_i` after that edge the line is sampled again. If the line is high at that point, the candidate is dropped with no output and the receiver waits for the next falling edge.
- R2: In asynchronous mode each later bit is sampled every 16 `os_tick_i` pulses after the start sample. Data bits are taken least significant first.
- R3: `cfg_size_i` sets the character width: codes 0,1,2,3,4 give 5,6,7,8,9 bits, and codes 5 to 7 also give 9 bits. `rx_data_o` is right-aligned, with zeros above the character width.
- R4: `cfg_par_i` selects parity: 2'b00 and 2'b01 mean no parity bit, 2'b10 even, 2'b11 odd. With even parity the bit makes the count of ones across data plus parity even; with odd parity it makes that count odd. `rx_perr_o` flags a parity bit that breaks this rule. It is never set when parity is off.
- R5: `rx_ferr_o` is set when the first stop bit is sampled low.
- R6: When `cfg_two_stop_i` is 1, the second stop bit is sampled but not checked. A low second stop bit raises no flag and never starts a frame.
- R7: `rx_valid_o` is high for exactly one clock per frame, after the first stop bit is sampled. `rx_perr_o` and `rx_ferr_o` are only ever high in that same cycle. `rx_data_o` holds the last character.
- R8: Frames that follow each other with no idle time are all received.
- R9: In synchronous slave mode (`cfg_sync_i`=1, `cfg_master_i`=0) the line is sampled on the falling edge of `xck_i` when `cfg_pol_i`=0, and on the rising edge when `cfg_pol_i`=1. An idle-high line sampled as low is a start bit.
- R10: In synchronous master mode `xck_o` toggles every 8 `os_tick_i` pulses, so a full period is 16 ticks. The line is sampled on the `xck_o` edge that R9 selects. In every other mode `xck_o` is low.
- R11: After reset `rx_valid_o`, `rx_perr_o`, `rx_ferr_o`, `rx_data_o` and `xck_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sync_i | input | 1 | 1 = clocked (synchronous) mode, 0 = asynchronous |
| cfg_master_i | input | 1 | In synchronous mode, 1 = drive `xck_o`, 0 = use `xck_i` |
| cfg_pol_i | input | 1 | Sampling edge: 0 = falling, 1 = rising |
| cfg_size_i | input | 3 | Character width code (R3) |
| cfg_par_i | input | 2 | Parity mode (R4) |
| cfg_two_stop_i | input | 1 | 1 = two stop bits |
| os_tick_i | input | 1 | Oversampling strobe, 16 per bit |
| rx_i | input | 1 | Serial receive line |
| xck_i | input | 1 | Bit clock from the far end (slave) |
| xck_o | output | 1 | Bit clock driven out (master) |
| rx_data_o | output | 9 | Received character, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe per received frame |
| rx_perr_o | output | 1 | Parity error, valid with the strobe |
| rx_ferr_o | output | 1 | Framing error, valid with the strobe |

## Verification
The hardest case to reach is a wrong choice of sampling edge in clocked mode. If the bench changed the data exactly on the change edge, sampling on the wrong edge would still capture every bit, only half a period late. To expose the error, the bench changes the line a few clocks after the change edge, so a receiver that samples on the change edge picks up the previous bit. The same effect shows up in master mode, because the bench times its data from `xck_o` edges. The two-stop-bit case sends a low second stop bit. A receiver that does not use up that bit treats it as a new start bit and produces an extra frame, which the scoreboard reports.

// File: rtl/usrx_pkg.sv
package usrx_pkg;

  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5
  } rx_state_e;

  // Width code -> number of character bits (codes above 4 saturate at 9)
  function automatic logic [CNT_W-1:0] char_len(input logic [2:0] code);
    if (code > 3'd4) return CNT_W'(MAX_BITS);
    return CNT_W'(code) + CNT_W'(5);
  endfunction

endpackage

// File: rtl/usrx_rst_sync.sv
module usrx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/usrx_sync.sv
module usrx_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] st_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign st_d[g] = d_i;
    end else begin : g_next
      assign st_d[g] = st_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= RST_VAL;
      else        st_q[g] <= st_d[g];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/usrx_timing.sv
module usrx_timing #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_sync,
  input  logic cfg_master,
  input  logic cfg_pol,
  input  logic os_tick,
  input  logic restart,
  input  logic xck_s,
  output logic samp_stb,
  output logic xck_o
);

  localparam int unsigned HALF = OVS / 2;
  localparam int unsigned PW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] PH_MID  = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [HW-1:0] HC_LAST = HW'(HALF - 1);

  // Asynchronous bit-phase counter
  logic [PW-1:0] ph_q, ph_d;
  logic          ph_en;
  logic          astb;

  always_comb begin
    ph_en = restart | os_tick;
    if (restart)            ph_d = '0;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                    ph_d = ph_q + PW'(1);
  end

  assign astb = os_tick & ~restart & (ph_q == PH_MID);

  // Master bit-clock divider
  logic          run;
  logic [HW-1:0] hc_q, hc_d;
  logic          xq_q, xq_d;
  logic          mstb;

  assign run = cfg_sync & cfg_master;

  always_comb begin
    hc_d = hc_q;
    xq_d = xq_q;
    if (!run) begin
      hc_d = '0;
      xq_d = 1'b0;
    end else if (os_tick) begin
      if (hc_q == HC_LAST) begin
        hc_d = '0;
        xq_d = ~xq_q;
      end else begin
        hc_d = hc_q + HW'(1);
      end
    end
  end

  // Sampling edge: falling when pol=0 (level leaves 1), rising when pol=1
  assign mstb = run & os_tick & (hc_q == HC_LAST) & (xq_q != cfg_pol);

  // Slave bit-clock edges
  logic xs_prev_q;
  logic s_rise, s_fall, sstb;

  assign s_rise = xck_s & ~xs_prev_q;
  assign s_fall = ~xck_s & xs_prev_q;
  assign sstb   = cfg_pol ? s_rise : s_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= '0;
      hc_q      <= '0;
      xq_q      <= 1'b0;
      xs_prev_q <= 1'b0;
    end else begin
      if (ph_en) ph_q <= ph_d;
      hc_q      <= hc_d;
      xq_q      <= xq_d;
      xs_prev_q <= xck_s;
    end
  end

  always_comb begin
    if (!cfg_sync)       samp_stb = astb;
    else if (cfg_master) samp_stb = mstb;
    else                 samp_stb = sstb;
  end

  assign xck_o = xq_q;

  p_async_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sync && samp_stb) |-> os_tick);

  p_xck_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !xck_o);

  p_xck_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !os_tick) |=> $stable(xck_o));

endmodule

// File: rtl/usrx_frame.sv
module usrx_frame
  import usrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sync,
  input  logic [2:0]          cfg_size,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_two_stop,
  input  logic                rx_s,
  input  logic                samp_stb,
  output logic                restart,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                perr_o,
  output logic                ferr_o
);

  rx_state_e            st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [MAX_BITS-1:0]  sh_q, sh_d;
  logic [MAX_BITS-1:0]  data_q, data_d;
  logic                 pacc_q, pacc_d;
  logic                 pbit_q, pbit_d;
  logic                 vld_q, vld_d;
  logic                 perr_q, perr_d;
  logic                 ferr_q, ferr_d;
  logic                 rx_prev_q;

  logic [CNT_W-1:0]     nbits;
  logic [CNT_W-1:0]     shamt;
  logic                 par_en;
  logic                 fall;

  assign nbits   = char_len(cfg_size);
  assign shamt   = CNT_W'(MAX_BITS) - nbits;
  assign par_en  = cfg_par[1];
  assign fall    = rx_prev_q & ~rx_s;
  assign restart = (st_q == ST_IDLE) & ~cfg_sync & fall;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    pacc_d = pacc_q;
    pbit_d = pbit_q;
    data_d = data_q;
    vld_d  = 1'b0;
    perr_d = 1'b0;
    ferr_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!cfg_sync) begin
          if (fall) st_d = ST_START;
        end else if (samp_stb && !rx_s) begin
          st_d   = ST_DATA;
          cnt_d  = '0;
          pacc_d = 1'b0;
        end
      end
      ST_START: begin
        if (samp_stb) begin
          if (!rx_s) begin
            st_d   = ST_DATA;
            cnt_d  = '0;
            pacc_d = 1'b0;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (samp_stb) begin
          sh_d   = {rx_s, sh_q[MAX_BITS-1:1]};
          pacc_d = pacc_q ^ rx_s;
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == nbits - CNT_W'(1)) st_d = par_en ? ST_PAR : ST_STOP1;
        end
      end
      ST_PAR: begin
        if (samp_stb) begin
          pbit_d = rx_s;
          st_d   = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (samp_stb) begin
          vld_d  = 1'b1;
          ferr_d = ~rx_s;
          perr_d = par_en & (pbit_q != (pacc_q ^ cfg_par[0]));
          data_d = sh_q >> shamt;
          st_d   = cfg_two_stop ? ST_STOP2 : ST_IDLE;
        end
      end
      ST_STOP2: begin
        if (samp_stb) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      data_q    <= '0;
      pacc_q    <= 1'b0;
      pbit_q    <= 1'b0;
      vld_q     <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      rx_prev_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      data_q    <= data_d;
      pacc_q    <= pacc_d;
      pbit_q    <= pbit_d;
      vld_q     <= vld_d;
      perr_q    <= perr_d;
      ferr_q    <= ferr_d;
      rx_prev_q <= rx_s;
    end
  end

  assign data_o  = data_q;
  assign valid_o = vld_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_flags_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_o || ferr_o) |-> valid_o);

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((data_o >> nbits) == '0));

  p_no_perr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !par_en) |-> !perr_o);

  p_glitch_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && samp_stb && rx_s) |=> (st_q == ST_IDLE && !valid_o));

endmodule

// File: rtl/usart_frame_rx.sv
module usart_frame_rx
  import usrx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                cfg_sync_i,
  input  logic                cfg_master_i,
  input  logic                cfg_pol_i,
  input  logic [2:0]          cfg_size_i,
  input  logic [1:0]          cfg_par_i,
  input  logic                cfg_two_stop_i,
  input  logic                os_tick_i,
  input  logic                rx_i,
  input  logic                xck_i,
  output logic                xck_o,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_valid_o,
  output logic                rx_perr_o,
  output logic                rx_ferr_o
);

  logic       rst_n;
  logic [1:0] pins_s;
  logic       restart;
  logic       samp_stb;

  usrx_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // bit 0: receive line (idle high), bit 1: slave bit clock
  usrx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({xck_i, rx_i}),
    .q_o   (pins_s)
  );

  usrx_timing #(.OVS(OVS)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sync   (cfg_sync_i),
    .cfg_master (cfg_master_i),
    .cfg_pol    (cfg_pol_i),
    .os_tick    (os_tick_i),
    .restart    (restart),
    .xck_s      (pins_s[1]),
    .samp_stb   (samp_stb),
    .xck_o      (xck_o)
  );

  usrx_frame u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sync     (cfg_sync_i),
    .cfg_size     (cfg_size_i),
    .cfg_par      (cfg_par_i),
    .cfg_two_stop (cfg_two_stop_i),
    .rx_s         (pins_s[0]),
    .samp_stb     (samp_stb),
    .restart      (restart),
    .data_o       (rx_data_o),
    .valid_o      (rx_valid_o),
    .perr_o       (rx_perr_o),
    .ferr_o       (rx_ferr_o)
  );

endmodule

// File: tb/tb_usart_frame_rx.sv
`timescale 1ns/1ps
module tb_usart_frame_rx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_sync, cfg_master, cfg_pol, cfg_two;
  logic [2:0] cfg_size;
  logic [1:0] cfg_par;
  logic       os_tick;
  logic       rx, xck_in;
  logic       xck_out;
  logic [8:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr;

  always #2.5 clk = ~clk;

  usart_frame_rx dut (
    .clk(clk), .rst_ni(rst_n),
    .cfg_sync_i(cfg_sync), .cfg_master_i(cfg_master), .cfg_pol_i(cfg_pol),
    .cfg_size_i(cfg_size), .cfg_par_i(cfg_par), .cfg_two_stop_i(cfg_two),
    .os_tick_i(os_tick), .rx_i(rx), .xck_i(xck_in), .xck_o(xck_out),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr)
  );

  typedef struct {
    logic [8:0] d;
    logic       pe;
    logic       fe;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int valid_seen = 0;
  bit done = 0;

  localparam int BITCLK = 64;  // 16 ticks x 4 clocks

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // oversampling strobe: one clock in four
  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        valid_seen++;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7: unexpected frame data=%0h, expected none", rx_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " data"}, rx_data == e.d, rx_data, e.d);
          check({e.tag, " perr"}, rx_perr == e.pe, rx_perr, e.pe);
          check({e.tag, " ferr"}, rx_ferr == e.fe, rx_ferr, e.fe);
        end
      end else if (rx_perr || rx_ferr) begin
        n_cmp++; n_bad++;
        $display("FAIL R7: flag without valid actual=%b%b expected=00", rx_perr, rx_ferr);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  task automatic set_cfg(input logic s, input logic m, input logic p,
                         input logic [2:0] sz, input logic [1:0] pr, input logic two);
    @(negedge clk);
    cfg_sync = s; cfg_master = m; cfg_pol = p;
    cfg_size = sz; cfg_par = pr; cfg_two = two;
    xck_in = p;
    repeat (8) @(negedge clk);
  endtask

  // build the bit sequence of a frame and queue its expected result
  task automatic make_frame(input string tag, input logic [8:0] d, input int nb,
                            input logic bad_p, input logic bad_s, input logic low_s2,
                            output logic [15:0] fb, output int len);
    logic [8:0] m;
    m = '0;
    for (int k = 0; k < nb; k++) m[k] = 1'b1;
    fb = '1;
    fb[0] = 1'b0;
    for (int k = 0; k < nb; k++) fb[1+k] = d[k];
    len = 1 + nb;
    if (cfg_par[1]) begin
      fb[len] = (^(d & m)) ^ cfg_par[0] ^ bad_p;
      len++;
    end
    fb[len] = ~bad_s;
    len++;
    if (cfg_two) begin
      fb[len] = ~low_s2;
      len++;
    end
    exp_q.push_back('{d & m, cfg_par[1] & bad_p, bad_s, tag});
  endtask

  task automatic send_async(input logic [15:0] fb, input int len, input int idle);
    for (int i = 0; i < len + idle; i++) begin
      rx = (i < len) ? fb[i] : 1'b1;
      repeat (BITCLK) @(negedge clk);
    end
  endtask

  task automatic send_slave(input logic [15:0] fb, input int len, input int idle);
    for (int i = 0; i < len + idle; i++) begin
      xck_in = ~cfg_pol;           // change edge
      repeat (3) @(negedge clk);
      rx = (i < len) ? fb[i] : 1'b1;
      repeat (5) @(negedge clk);
      xck_in = cfg_pol;            // sampling edge
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic wait_change_edge();
    if (cfg_pol) @(negedge xck_out);
    else         @(posedge xck_out);
  endtask

  task automatic send_master(input logic [15:0] fb, input int len, input int idle);
    for (int i = 0; i < len + idle; i++) begin
      wait_change_edge();
      repeat (3) @(negedge clk);
      rx = (i < len) ? fb[i] : 1'b1;
    end
    wait_change_edge();
    repeat (4) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    repeat (40) @(negedge clk);
    check({tag, " all frames seen"}, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    logic [15:0] fb, fb2;
    int len, len2, seen0;
    realtime t0, t1;

    rst_n = 1'b0; rx = 1'b1; xck_in = 1'b0;
    cfg_sync = 0; cfg_master = 0; cfg_pol = 0;
    cfg_size = 3'd3; cfg_par = 2'b00; cfg_two = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {rx_valid, rx_perr, rx_ferr, rx_data, xck_out} == '0,
          {rx_valid, rx_perr, rx_ferr, rx_data, xck_out}, 0);

    // R2 R8: async 8-bit, no parity, back to back
    set_cfg(0, 0, 0, 3'd3, 2'b00, 0);
    make_frame("R2 async 8N1 A5", 9'h0A5, 8, 0, 0, 0, fb, len);
    make_frame("R8 async back-to-back 3C", 9'h03C, 8, 0, 0, 0, fb2, len2);
    send_async(fb, len, 0);
    send_async(fb2, len2, 1);
    drained("R8");

    // R3 R4: 5-bit even parity good and bad; reserved code 01 = none
    set_cfg(0, 0, 0, 3'd0, 2'b10, 0);
    make_frame("R4 even parity ok", 9'h015, 5, 0, 0, 0, fb, len);
    send_async(fb, len, 0);
    make_frame("R4 even parity bad", 9'h00B, 5, 1, 0, 0, fb, len);
    send_async(fb, len, 1);
    set_cfg(0, 0, 0, 3'd1, 2'b01, 0);
    make_frame("R4 reserved code no parity", 9'h02D, 6, 0, 0, 0, fb, len);
    send_async(fb, len, 1);
    drained("R4");

    // R3: code 7 selects 9 bits, odd parity; 7-bit two stops back to back
    set_cfg(0, 0, 0, 3'd7, 2'b11, 0);
    make_frame("R3 9-bit odd parity", 9'h1A7, 9, 0, 0, 0, fb, len);
    send_async(fb, len, 0);
    make_frame("R4 odd parity bad", 9'h0F0, 9, 1, 0, 0, fb, len);
    send_async(fb, len, 1);
    set_cfg(0, 0, 0, 3'd2, 2'b00, 1);
    make_frame("R3 7-bit zero fill", 9'h1FF, 7, 0, 0, 0, fb, len);
    make_frame("R8 7-bit two stop back-to-back", 9'h055, 7, 0, 0, 0, fb2, len2);
    send_async(fb, len, 0);
    send_async(fb2, len2, 1);
    drained("R3");

    // R5: low first stop bit
    set_cfg(0, 0, 0, 3'd3, 2'b00, 0);
    make_frame("R5 framing error", 9'h081, 8, 0, 1, 0, fb, len);
    send_async(fb, len, 2);
    make_frame("R5 clean after ferr", 9'h042, 8, 0, 0, 0, fb, len);
    send_async(fb, len, 1);
    drained("R5");

    // R6: second stop low ignored in async
    set_cfg(0, 0, 0, 3'd3, 2'b00, 1);
    make_frame("R6 async low second stop", 9'h0C3, 8, 0, 0, 1, fb, len);
    send_async(fb, len, 1);
    make_frame("R6 async next frame", 9'h01E, 8, 0, 0, 0, fb, len);
    send_async(fb, len, 1);
    drained("R6");

    // R1: short low glitch rejected
    seen0 = valid_seen;
    @(negedge clk);
    rx = 1'b0;
    repeat (12) @(negedge clk);
    rx = 1'b1;
    repeat (200) @(negedge clk);
    check("R1 glitch gives no frame", valid_seen == seen0, valid_seen, seen0);
    make_frame("R1 frame after glitch", 9'h066, 8, 0, 0, 0, fb, len);
    send_async(fb, len, 1);
    drained("R1");

    // R9: slave clock, polarity 0
    set_cfg(1, 0, 0, 3'd3, 2'b00, 0);
    make_frame("R9 slave pol0 96", 9'h096, 8, 0, 0, 0, fb, len);
    make_frame("R9 slave pol0 back-to-back", 9'h069, 8, 0, 0, 0, fb2, len2);
    send_slave(fb, len, 0);
    send_slave(fb2, len2, 2);
    set_cfg(1, 0, 0, 3'd1, 2'b10, 0);
    make_frame("R9 slave pol0 6-bit even", 9'h033, 6, 0, 0, 0, fb, len);
    send_slave(fb, len, 2);
    drained("R9 pol0");

    // R9: slave clock, polarity 1
    set_cfg(1, 0, 1, 3'd3, 2'b11, 0);
    make_frame("R9 slave pol1 5A bad parity", 9'h05A, 8, 1, 0, 0, fb, len);
    send_slave(fb, len, 2);
    make_frame("R9 slave pol1 C1", 9'h0C1, 8, 0, 0, 0, fb, len);
    send_slave(fb, len, 2);
    drained("R9 pol1");

    // R6: sync low second stop must not start a frame
    set_cfg(1, 0, 0, 3'd3, 2'b00, 1);
    make_frame("R6 sync low second stop", 9'h0E7, 8, 0, 0, 1, fb, len);
    send_slave(fb, len, 3);
    drained("R6 sync");

    // R10: master clock period and reception
    set_cfg(1, 1, 0, 3'd3, 2'b00, 0);
    @(posedge xck_out); t0 = $realtime;
    @(posedge xck_out); t1 = $realtime;
    check("R10 xck_o period clocks", int'((t1 - t0) / 5.0) == 64, int'((t1 - t0) / 5.0), 64);
    make_frame("R10 master pol0 B4", 9'h0B4, 8, 0, 0, 0, fb, len);
    send_master(fb, len, 1);
    set_cfg(1, 1, 1, 3'd4, 2'b10, 0);
    make_frame("R10 master pol1 9-bit", 9'h14B, 9, 0, 0, 0, fb, len);
    send_master(fb, len, 1);
    drained("R10");

    set_cfg(0, 0, 0, 3'd3, 2'b00, 0);
    repeat (70) @(negedge clk);
    check("R10 xck_o low outside master", xck_out == 1'b0, xck_out, 0);
    check("R7 no extra frames", exp_q.size() == 0, exp_q.size(), 0);

    finish_run();
  end

endmodule